// File: doc/BRIEF.md
# Dual Q15 multiply-accumulate unit

This block is the arithmetic core of a two-lane signed 16-bit SIMD multiply-accumulate operation. One operation reads two 32-bit source words, each holding two signed 16-bit halves, and two 32-bit accumulator words called A and D. It forms one signed product per lane, adds it to or subtracts it from that lane's accumulator, and may round the sums. The result is either two full 32-bit sums or one packed word that holds the two rounded high halves. Lane 0 always accumulates into A and lane 1 into D.

A 6-bit minor opcode selects one of three modes: plain integer accumulate, Q15 fractional accumulate with two separate results, or Q15 fractional accumulate with a packed result. A 2-bit operand pattern chooses which source halves each lane multiplies. A 2-bit accumulate pattern chooses add or subtract for each lane. Two control bits come from the surrounding control register. One enables rounding. The other forces a plain half-up increment in packed mode; when it is clear, packed mode rounds half to even.

The datapath between the inputs and the result register is combinational. A valid operation presented with `in_valid` produces its result on the outputs one clock later, together with `out_valid`. The register file, instruction fetch and any saturation are outside this block.

Top module: `dq15_mac_unit`

## Requirements
- R1: Opcode 0x0A selects integer mode, 0x0B selects fractional packed mode and 0x0F selects fractional split mode. An operation with any other opcode leaves `out_valid` low in the next cycle and changes no result output.
- R2: A legal operation sampled with `in_valid` high at a rising edge sets `out_valid` high after that edge, with its results on the outputs. While `rst_n` is low, `out_valid`, `out_wr_d`, `out_res_a` and `out_res_d` are all zero.
- R3: Halves are referred to as B.hi = bits 31:16 and B.lo = bits 15:0, and the same for C. The operand pattern selects the products as (lane 0, lane 1): 0 gives (B.hi×C.hi, B.lo×C.lo), 1 gives (B.lo×C.hi, B.hi×C.lo), 2 gives (B.hi×C.hi, B.hi×C.lo), 3 gives (B.lo×C.hi, B.lo×C.lo). Every product is signed 16×16 giving 32 bits.
- R4: Accumulate pattern bit 1 makes lane 0 compute A minus product, and bit 0 makes lane 1 compute D minus product. A clear bit means add. All sums wrap modulo 2^32.
- R5: In integer mode the product is not shifted and no rounding is applied. Lane 0's sum appears on `out_res_a`, lane 1's sum on `out_res_d`, and `out_wr_d` is 1.
- R6: In both fractional modes each product is shifted left by one bit, modulo 2^32, before it is accumulated.
- R7: In fractional split mode with the round-enable input high, 0x8000 is added to both 32-bit sums. The results go to `out_res_a` and `out_res_d`, with `out_wr_d` = 1.
- R8: In packed mode with round enable high and the force-increment input low, a lane whose sum has its low 17 bits equal to 0x08000 gets no increment. Every other lane gets 0x8000 added.
- R9: In packed mode with round enable high and the force-increment input high, 0x8000 is added to both sums.
- R10: In packed mode `out_res_a` holds bits 31:16 of lane 0's rounded sum in bits 31:16 and bits 31:16 of lane 1's rounded sum in bits 15:0. `out_res_d` is 0 and `out_wr_d` is 0.
- R11: With round enable low, no mode rounds. The force-increment input has no effect in split or integer mode, and round enable has no effect in integer mode.
- R12: In a cycle after which no legal operation was sampled, `out_res_a`, `out_res_d` and `out_wr_d` keep their previous values.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| in_valid | input | 1 | Operation present this cycle |
| in_opcode | input | 6 | Minor opcode selecting the mode |
| in_opsel | input | 2 | Operand half-pairing pattern |
| in_accsel | input | 2 | Per-lane add/subtract pattern (bit 1 lane 0, bit 0 lane 1) |
| in_rnd_en | input | 1 | Control-register round enable (control bit 1) |
| in_rnd_force | input | 1 | Control-register force-increment select (control bit 2) |
| in_src_b | input | 32 | First source word, two signed halves |
| in_src_c | input | 32 | Second source word, two signed halves |
| in_acc_a | input | 32 | Lane 0 accumulator |
| in_acc_d | input | 32 | Lane 1 accumulator |
| out_valid | output | 1 | Result of a legal operation is present |
| out_wr_d | output | 1 | The D result is meaningful and is to be written |
| out_res_a | output | 32 | Result for register A (sum or packed word) |
| out_res_d | output | 32 | Result for register D |

## Verification
Every result, including `out_valid`, is due exactly one rising edge after the edge that samples the operation. The bench changes inputs on falling edges, keeps `in_valid` high for one clock and reads all four outputs at the next falling edge, half a period after the result register loads. For illegal opcodes and idle cycles, the bench checks at that same falling edge that the previous result is still held. The rounding ties are placed in the low 17 bits of the accumulators with zero products, so each tie outcome can be predicted exactly.

// File: rtl/dq15_pkg.sv
package dq15_pkg;

    localparam int OPC_W = 6;

    localparam logic [OPC_W-1:0] OPC_MAC_INT   = 6'h0A;
    localparam logic [OPC_W-1:0] OPC_MAC_PACK  = 6'h0B;
    localparam logic [OPC_W-1:0] OPC_MAC_SPLIT = 6'h0F;

    typedef enum logic [1:0] {
        MODE_NONE  = 2'd0,
        MODE_INT   = 2'd1,
        MODE_PACK  = 2'd2,
        MODE_SPLIT = 2'd3
    } mac_mode_e;

    function automatic logic mode_is_frac(mac_mode_e m);
        return (m == MODE_PACK) || (m == MODE_SPLIT);
    endfunction

endpackage

// File: rtl/dq15_decode.sv
module dq15_decode
    import dq15_pkg::*;
(
    input  logic             in_valid,
    input  logic [OPC_W-1:0] opcode,
    output mac_mode_e        mode,
    output logic             fire
);

    always_comb begin
        case (opcode)
            OPC_MAC_INT:   mode = MODE_INT;
            OPC_MAC_PACK:  mode = MODE_PACK;
            OPC_MAC_SPLIT: mode = MODE_SPLIT;
            default:       mode = MODE_NONE;
        endcase
        fire = in_valid && (mode != MODE_NONE);
    end

endmodule

// File: rtl/dq15_lane_mul.sv
module dq15_lane_mul #(
    parameter int HALF_W = 16,
    parameter int LANE   = 0
) (
    input  logic [2*HALF_W-1:0] src_b,
    input  logic [HALF_W-1:0]   c_half,
    input  logic [1:0]          opsel,
    input  logic                frac,
    output logic [2*HALF_W-1:0] prod
);

    localparam int WORD_W = 2 * HALF_W;

    logic [HALF_W-1:0] b_hi, b_lo, op_b;
    logic [WORD_W-1:0] ext_b, ext_c, raw;

    assign b_hi = src_b[WORD_W-1:HALF_W];
    assign b_lo = src_b[HALF_W-1:0];

    // Lane 0 uses the high half of B for patterns 0 and 2; lane 1 uses it for 1 and 2.
    generate
        if (LANE == 0) begin : g_lane0
            always_comb op_b = opsel[0] ? b_lo : b_hi;
        end else begin : g_lane1
            always_comb op_b = (opsel[0] ^ opsel[1]) ? b_hi : b_lo;
        end
    endgenerate

    always_comb begin
        ext_b = {{HALF_W{op_b[HALF_W-1]}}, op_b};
        ext_c = {{HALF_W{c_half[HALF_W-1]}}, c_half};
        raw   = ext_b * ext_c;
        prod  = frac ? {raw[WORD_W-2:0], 1'b0} : raw;
    end

endmodule

// File: rtl/dq15_lane_acc.sv
module dq15_lane_acc
    import dq15_pkg::*;
#(
    parameter int HALF_W = 16
) (
    input  logic [2*HALF_W-1:0] acc,
    input  logic [2*HALF_W-1:0] prod,
    input  logic                sub,
    input  mac_mode_e           mode,
    input  logic                rnd_en,
    input  logic                rnd_force,
    output logic [2*HALF_W-1:0] sum_out
);

    localparam int WORD_W = 2 * HALF_W;
    localparam logic [WORD_W-1:0] RND_INC = WORD_W'(1) << (HALF_W - 1);
    localparam logic [HALF_W:0]   TIE_PAT = (HALF_W + 1)'(1) << (HALF_W - 1);

    logic [WORD_W-1:0] raw_sum;
    logic              tie;
    logic              add_rnd;

    always_comb begin
        raw_sum = sub ? (acc - prod) : (acc + prod);
        tie     = (raw_sum[HALF_W:0] == TIE_PAT);
        case (mode)
            MODE_SPLIT: add_rnd = rnd_en;
            MODE_PACK:  add_rnd = rnd_en && (rnd_force || !tie);
            default:    add_rnd = 1'b0;
        endcase
        sum_out = raw_sum + (add_rnd ? RND_INC : '0);
    end

endmodule

// File: rtl/dq15_mac_unit.sv
module dq15_mac_unit
    import dq15_pkg::*;
#(
    parameter int DATA_W = 32
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              in_valid,
    input  logic [OPC_W-1:0]  in_opcode,
    input  logic [1:0]        in_opsel,
    input  logic [1:0]        in_accsel,
    input  logic              in_rnd_en,
    input  logic              in_rnd_force,
    input  logic [DATA_W-1:0] in_src_b,
    input  logic [DATA_W-1:0] in_src_c,
    input  logic [DATA_W-1:0] in_acc_a,
    input  logic [DATA_W-1:0] in_acc_d,
    output logic              out_valid,
    output logic              out_wr_d,
    output logic [DATA_W-1:0] out_res_a,
    output logic [DATA_W-1:0] out_res_d
);

    localparam int HALF_W = DATA_W / 2;
    localparam int NLANE  = 2;

    typedef struct packed {
        logic              valid;
        logic              wr_d;
        logic [DATA_W-1:0] res_a;
        logic [DATA_W-1:0] res_d;
    } mac_state_t;

    mac_mode_e         mode;
    logic              fire;
    logic              frac;
    logic [DATA_W-1:0] lane_prod [NLANE];
    logic [DATA_W-1:0] lane_sum  [NLANE];
    mac_state_t        state_d, state_q;

    dq15_decode dec_i (
        .in_valid (in_valid),
        .opcode   (in_opcode),
        .mode     (mode),
        .fire     (fire)
    );

    assign frac = mode_is_frac(mode);

    for (genvar ln = 0; ln < NLANE; ln++) begin : g_lane
        dq15_lane_mul #(.HALF_W(HALF_W), .LANE(ln)) mul_i (
            .src_b  (in_src_b),
            .c_half ((ln == 0) ? in_src_c[DATA_W-1:HALF_W] : in_src_c[HALF_W-1:0]),
            .opsel  (in_opsel),
            .frac   (frac),
            .prod   (lane_prod[ln])
        );

        dq15_lane_acc #(.HALF_W(HALF_W)) acc_i (
            .acc       ((ln == 0) ? in_acc_a : in_acc_d),
            .prod      (lane_prod[ln]),
            .sub       (in_accsel[NLANE-1-ln]),
            .mode      (mode),
            .rnd_en    (in_rnd_en),
            .rnd_force (in_rnd_force),
            .sum_out   (lane_sum[ln])
        );
    end

    always_comb begin
        state_d       = state_q;
        state_d.valid = fire;
        if (fire) begin
            if (mode == MODE_PACK) begin
                state_d.res_a = {lane_sum[0][DATA_W-1:HALF_W], lane_sum[1][DATA_W-1:HALF_W]};
                state_d.res_d = '0;
                state_d.wr_d  = 1'b0;
            end else begin
                state_d.res_a = lane_sum[0];
                state_d.res_d = lane_sum[1];
                state_d.wr_d  = 1'b1;
            end
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) state_q <= '0;
        else        state_q <= state_d;
    end

    assign out_valid = state_q.valid;
    assign out_wr_d  = state_q.wr_d;
    assign out_res_a = state_q.res_a;
    assign out_res_d = state_q.res_d;

endmodule

// File: rtl/dq15_mac_chk.sv
module dq15_mac_chk
    import dq15_pkg::*;
#(
    parameter int DATA_W = 32
) (
    input logic              clk,
    input logic              rst_n,
    input logic              in_valid,
    input logic [OPC_W-1:0]  in_opcode,
    input logic [1:0]        in_opsel,
    input logic [1:0]        in_accsel,
    input logic [DATA_W/2-1:0] b_hi,
    input logic [DATA_W/2-1:0] c_hi,
    input logic [DATA_W-1:0] in_acc_a,
    input logic              out_valid,
    input logic              out_wr_d,
    input logic [DATA_W-1:0] out_res_a,
    input logic [DATA_W-1:0] out_res_d
);

    localparam int HALF_W = DATA_W / 2;

    logic              legal_in;
    logic [DATA_W-1:0] hh_sum;

    assign legal_in = in_valid && (in_opcode == 6'h0A || in_opcode == 6'h0B || in_opcode == 6'h0F);
    assign hh_sum   = in_acc_a + ({{HALF_W{b_hi[HALF_W-1]}}, b_hi} * {{HALF_W{c_hi[HALF_W-1]}}, c_hi});

    AST_LEGAL_GIVES_VALID: assert property (@(posedge clk) disable iff (!rst_n)
        legal_in |=> out_valid);                                                    // R2
    AST_ILLEGAL_NO_VALID: assert property (@(posedge clk) disable iff (!rst_n)
        !legal_in |=> !out_valid);                                                  // R1
    AST_PACK_ONLY_A: assert property (@(posedge clk) disable iff (!rst_n)
        (in_valid && in_opcode == 6'h0B) |=> (!out_wr_d && out_res_d == '0));       // R10
    AST_WIDE_BOTH_DEST: assert property (@(posedge clk) disable iff (!rst_n)
        (in_valid && (in_opcode == 6'h0A || in_opcode == 6'h0F)) |=> out_wr_d);     // R5
    AST_IDLE_HOLDS: assert property (@(posedge clk) disable iff (!rst_n)
        !legal_in |=> ($stable(out_res_a) && $stable(out_res_d) && $stable(out_wr_d))); // R12
    AST_INT_HIGH_PAIR: assert property (@(posedge clk) disable iff (!rst_n)
        (in_valid && in_opcode == 6'h0A && in_opsel == 2'd0 && in_accsel == 2'd0)
        |=> (out_res_a == $past(hh_sum)));                                          // R3

endmodule

bind dq15_mac_unit dq15_mac_chk #(.DATA_W(DATA_W)) chk_i (
    .clk       (clk),
    .rst_n     (rst_n),
    .in_valid  (in_valid),
    .in_opcode (in_opcode),
    .in_opsel  (in_opsel),
    .in_accsel (in_accsel),
    .b_hi      (in_src_b[DATA_W-1:DATA_W/2]),
    .c_hi      (in_src_c[DATA_W-1:DATA_W/2]),
    .in_acc_a  (in_acc_a),
    .out_valid (out_valid),
    .out_wr_d  (out_wr_d),
    .out_res_a (out_res_a),
    .out_res_d (out_res_d)
);

// File: tb/dq15_mac_unit_tb_top.sv
module dq15_mac_unit_tb_top;

    logic        clk = 1'b0;
    logic        rst_n;
    logic        in_valid;
    logic [5:0]  in_opcode;
    logic [1:0]  in_opsel, in_accsel;
    logic        in_rnd_en, in_rnd_force;
    logic [31:0] in_src_b, in_src_c, in_acc_a, in_acc_d;
    logic        out_valid, out_wr_d;
    logic [31:0] out_res_a, out_res_d;

    int n_checks = 0;
    int n_fail   = 0;

    // model's view of the held result
    logic        m_wr;
    logic [31:0] m_a, m_d;

    always #5 clk = ~clk;

    dq15_mac_unit dut_i (
        .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .in_opcode(in_opcode),
        .in_opsel(in_opsel), .in_accsel(in_accsel), .in_rnd_en(in_rnd_en),
        .in_rnd_force(in_rnd_force), .in_src_b(in_src_b), .in_src_c(in_src_c),
        .in_acc_a(in_acc_a), .in_acc_d(in_acc_d), .out_valid(out_valid),
        .out_wr_d(out_wr_d), .out_res_a(out_res_a), .out_res_d(out_res_d)
    );

    localparam int NV = 12;
    localparam logic [31:0] V_B [NV] = '{32'h0000_0000, 32'h4000_0002, 32'h8000_8000, 32'h7FFF_7FFF,
                                         32'hFFFF_0001, 32'h1234_ABCD, 32'h8000_7FFF, 32'h0001_FFFF,
                                         32'h0000_0000, 32'h5555_AAAA, 32'hC000_3FFF, 32'h0100_0080};
    localparam logic [31:0] V_C [NV] = '{32'h1234_5678, 32'h4000_0003, 32'h8000_8000, 32'h8000_7FFF,
                                         32'hFFFF_FFFF, 32'h0F0F_F0F0, 32'h7FFF_8000, 32'h8000_0001,
                                         32'hFFFF_FFFF, 32'hAAAA_5555, 32'h0002_FFFE, 32'h0080_0100};
    localparam logic [31:0] V_A [NV] = '{32'h1234_8000, 32'h0000_0000, 32'h8000_0000, 32'h0000_8000,
                                         32'h7FFF_FFFF, 32'hDEAD_BEEF, 32'h0001_8000, 32'hFFFF_8000,
                                         32'h0003_8000, 32'h0000_0001, 32'hFFFF_FFFF, 32'h0000_7FFF};
    localparam logic [31:0] V_D [NV] = '{32'h1235_8000, 32'h0000_0005, 32'h8000_0000, 32'h0001_8000,
                                         32'h8000_0000, 32'hCAFE_F00D, 32'h0000_8000, 32'h0002_8000,
                                         32'h0004_8000, 32'hFFFF_FFFF, 32'h0000_0000, 32'h0001_7FFF};
    localparam logic [5:0]  V_OPC [4] = '{6'h0A, 6'h0B, 6'h0F, 6'h09};

    task automatic check(input string tag, input logic [65:0] act, input logic [65:0] exp);
        n_checks++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s actual valid=%0b wr_d=%0b a=%08h d=%08h expected valid=%0b wr_d=%0b a=%08h d=%08h",
                     tag, act[65], act[64], act[63:32], act[31:0], exp[65], exp[64], exp[63:32], exp[31:0]);
        end
    endtask

    // independent behavioural reference
    task automatic ref_mac(input logic [5:0] opc, input logic [1:0] ops, input logic [1:0] acs,
                           input logic ren, input logic rfor,
                           input logic [31:0] b, input logic [31:0] c,
                           input logic [31:0] a, input logic [31:0] d,
                           output logic v);
        longint bh, bl, ch, cl, x0, x1, p0, p1;
        logic [31:0] s0, s1;
        logic is_frac, legal;
        bh = longint'($signed(b[31:16])); bl = longint'($signed(b[15:0]));
        ch = longint'($signed(c[31:16])); cl = longint'($signed(c[15:0]));
        case (ops)
            2'd0: begin x0 = bh; x1 = bl; end
            2'd1: begin x0 = bl; x1 = bh; end
            2'd2: begin x0 = bh; x1 = bh; end
            default: begin x0 = bl; x1 = bl; end
        endcase
        p0 = x0 * ch;
        p1 = x1 * cl;
        legal   = (opc == 6'h0A) || (opc == 6'h0B) || (opc == 6'h0F);
        is_frac = (opc == 6'h0B) || (opc == 6'h0F);
        if (is_frac) begin p0 = p0 * 2; p1 = p1 * 2; end
        s0 = acs[1] ? a - p0[31:0] : a + p0[31:0];
        s1 = acs[0] ? d - p1[31:0] : d + p1[31:0];
        if (is_frac && ren) begin
            if (opc == 6'h0F) begin
                s0 = s0 + 32'h8000; s1 = s1 + 32'h8000;
            end else begin
                if (rfor || (s0 & 32'h1FFFF) != 32'h8000) s0 = s0 + 32'h8000;
                if (rfor || (s1 & 32'h1FFFF) != 32'h8000) s1 = s1 + 32'h8000;
            end
        end
        v = legal;
        if (legal) begin
            if (opc == 6'h0B) begin m_a = {s0[31:16], s1[31:16]}; m_d = 32'h0; m_wr = 1'b0; end
            else              begin m_a = s0; m_d = s1; m_wr = 1'b1; end
        end
    endtask

    task automatic issue(input logic [5:0] opc, input logic [1:0] ops, input logic [1:0] acs,
                         input logic ren, input logic rfor,
                         input logic [31:0] b, input logic [31:0] c,
                         input logic [31:0] a, input logic [31:0] d);
        @(negedge clk);
        in_valid = 1'b1; in_opcode = opc; in_opsel = ops; in_accsel = acs;
        in_rnd_en = ren; in_rnd_force = rfor;
        in_src_b = b; in_src_c = c; in_acc_a = a; in_acc_d = d;
        @(negedge clk);
        in_valid = 1'b0;
    endtask

    function automatic logic [65:0] outs();
        return {out_valid, out_wr_d, out_res_a, out_res_d};
    endfunction

    initial begin : watchdog
        #(10 * 200000);
        n_fail++;
        $display("FAIL watchdog expired");
        $display("  TB_RESULT checks=%0d failures=%0d", n_checks, n_fail);
        $finish;
    end

    initial begin : main
        logic v;
        string tag;
        rst_n = 1'b0; in_valid = 1'b0; in_opcode = '0; in_opsel = '0; in_accsel = '0;
        in_rnd_en = 1'b0; in_rnd_force = 1'b0;
        in_src_b = '0; in_src_c = '0; in_acc_a = '0; in_acc_d = '0;
        m_a = '0; m_d = '0; m_wr = 1'b0;
        repeat (3) @(negedge clk);
        check("R2 reset state", outs(), 66'h0);
        rst_n = 1'b1;

        // table walk: every vector, mode, operand pattern, accumulate pattern and rounding control
        for (int i = 0; i < NV * 4 * 16 * 4; i++) begin
            automatic int vi = i / 256;
            automatic int mo = (i / 64) % 4;
            automatic logic [1:0] ops = 2'((i / 16) % 4);
            automatic logic [1:0] acs = 2'((i / 4) % 4);
            automatic logic ren  = i[0];
            automatic logic rfor = i[1];
            ref_mac(V_OPC[mo], ops, acs, ren, rfor, V_B[vi], V_C[vi], V_A[vi], V_D[vi], v);
            issue(V_OPC[mo], ops, acs, ren, rfor, V_B[vi], V_C[vi], V_A[vi], V_D[vi]);
            case (mo)
                0:       tag = "R5 R3 R4 integer";
                1:       tag = "R10 R8 R9 packed";
                2:       tag = "R6 R7 R11 split";
                default: tag = "R1 illegal opcode";
            endcase
            check(tag, outs(), {v, m_wr, m_a, m_d});
        end

        // R5: integer products, no shift
        issue(6'h0A, 2'd0, 2'd0, 1'b1, 1'b1, 32'h4000_0002, 32'h4000_0003, 32'h0, 32'h0);
        check("R5 integer products", outs(), {2'b11, 32'h1000_0000, 32'h0000_0006});
        // R6: fractional doubles the products
        issue(6'h0F, 2'd0, 2'd0, 1'b0, 1'b0, 32'h4000_0002, 32'h4000_0003, 32'h0, 32'h0);
        check("R6 fractional shift", outs(), {2'b11, 32'h2000_0000, 32'h0000_000C});
        // R4: subtract lane 0, add lane 1
        issue(6'h0A, 2'd0, 2'b10, 1'b0, 1'b0, 32'h4000_0002, 32'h4000_0003, 32'h5, 32'h0);
        check("R4 lane0 subtract", outs(), {2'b11, 32'hF000_0005, 32'h0000_0006});
        // R4: modulo wrap of -1.0 * -1.0 in fractional mode
        issue(6'h0F, 2'd0, 2'd0, 1'b0, 1'b0, 32'h8000_0000, 32'h8000_0000, 32'h8000_0000, 32'h1);
        check("R4 wraparound", outs(), {2'b11, 32'h0000_0000, 32'h0000_0001});
        // R3: pattern 1 picks B.lo*C.hi and B.hi*C.lo
        issue(6'h0A, 2'd1, 2'd0, 1'b0, 1'b0, 32'h0003_0005, 32'h0007_000B, 32'h0, 32'h0);
        check("R3 cross pattern", outs(), {2'b11, 32'h0000_0023, 32'h0000_0021});
        // R8: tie on lane 0 kept, lane 1 rounded
        issue(6'h0B, 2'd0, 2'd0, 1'b1, 1'b0, 32'h0, 32'h0, 32'h1234_8000, 32'h1235_8000);
        check("R8 half-even tie", outs(), {2'b10, 32'h1234_1236, 32'h0});
        // R9: forced increment on both lanes
        issue(6'h0B, 2'd0, 2'd0, 1'b1, 1'b1, 32'h0, 32'h0, 32'h1234_8000, 32'h1235_8000);
        check("R9 forced increment", outs(), {2'b10, 32'h1235_1236, 32'h0});
        // R10 R11: packed, rounding disabled
        issue(6'h0B, 2'd0, 2'd0, 1'b0, 1'b1, 32'h0, 32'h0, 32'h1234_8000, 32'h1235_8000);
        check("R10 R11 packed truncation", outs(), {2'b10, 32'h1234_1235, 32'h0});
        // R7 R11: split always increments regardless of force bit
        issue(6'h0F, 2'd0, 2'd0, 1'b1, 1'b0, 32'h0, 32'h0, 32'h1234_8000, 32'h1235_8000);
        check("R7 split rounding", outs(), {2'b11, 32'h1235_0000, 32'h1236_0000});
        // R11: integer ignores both round controls
        issue(6'h0A, 2'd0, 2'd0, 1'b1, 1'b1, 32'h0, 32'h0, 32'h1234_8000, 32'h1235_8000);
        check("R11 integer no rounding", outs(), {2'b11, 32'h1234_8000, 32'h1235_8000});
        // R1: illegal opcode holds previous result
        issue(6'h0E, 2'd0, 2'd0, 1'b1, 1'b1, 32'h1111_1111, 32'h2222_2222, 32'h3, 32'h4);
        check("R1 illegal opcode", outs(), {2'b01, 32'h1234_8000, 32'h1235_8000});
        // R12: idle cycles hold
        in_acc_a = 32'hFFFF_FFFF; in_opcode = 6'h0A;
        repeat (2) @(negedge clk);
        check("R12 idle hold", outs(), {2'b01, 32'h1234_8000, 32'h1235_8000});
        // R2: reset mid-run clears
        rst_n = 1'b0;
        @(negedge clk);
        check("R2 reset clears", outs(), 66'h0);
        rst_n = 1'b1;
        issue(6'h0A, 2'd0, 2'd0, 1'b0, 1'b0, 32'h0, 32'h0, 32'h7, 32'h9);
        check("R2 one-cycle latency", outs(), {2'b11, 32'h7, 32'h9});

        $display("  TB_RESULT checks=%0d failures=%0d", n_checks, n_fail);
        $finish;
    end

endmodule